// File: doc/BRIEF.md
# AND-OR Array Complexity and Training Error Evaluator

This block sits beside a programmable two-level AND-OR array whose configuration is held in a wide architecture register. On request it walks that register one product term per clock and derives three size figures for the configured circuit. A host weighs these figures against training error when it ranks candidate configurations. The same block also tallies classification errors over a stream of training samples. Each sample presents the class vector the array should produce next to the vector it actually produced.

The tally runs in epochs. A closing strobe freezes the sample count and the error count into report registers and starts the next epoch from zero. The host divides the two report values to obtain the error rate, and it does the logarithmic weighting itself.

Top module: `logic_array_cost_eval`

## Requirements
- R1: Term t occupies `arch_bits[t*(2*IN_BITS+OUTS) +: 2*IN_BITS+OUTS]`. Inside a term, bits `[OUTS-1:0]` are its output connections (bit o set means the term feeds output o) and the upper `2*IN_BITS` bits are its literal selections. A term is live only when at least one literal bit and at least one connection bit are set. `used_terms` counts the live terms.
- R2: `c1_out` is the sum over all outputs of the number of live terms feeding that output.
- R3: `c2_out` equals `used_terms` multiplied by the total number of output connections of live terms.
- R4: `c3_out` is the sum over outputs of the square of that output's live-term count. A circuit with one live term on output 0 and two on output 1 gives C1=3, C2=9, C3=5.
- R5: `scan_ready` goes high after the TERMS-th rising edge that follows the edge sampling `scan_start`. It stays high, with all results unchanged, until the next `scan_start`.
- R6: A `scan_start` during a scan abandons it. `scan_ready` is low after that edge, all counts restart from zero, and the full TERMS-cycle walk repeats over the current register contents.
- R7: Every sample with `pat_valid` high adds one to the sample count. A sample adds one to the error count when any bit of `pat_actual` differs from `pat_expect`, whether one bit or several differ.
- R8: Both running counts saturate at 2^CNT_W-1 and never wrap.
- R9: `epoch_done` copies the counts, including a sample presented in the same cycle, into `rpt_patterns` and `rpt_errors`. It pulses `rpt_valid` for exactly one cycle and restarts both running counts at zero. The report registers hold their values until the next `epoch_done`.
- R10: After reset, `scan_ready`, `rpt_valid`, all complexity outputs and both report values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arch_bits | input | TERMS*(2*IN_BITS+OUTS) | Architecture register contents, held stable while a scan runs |
| scan_start | input | 1 | Starts or restarts the complexity walk |
| scan_ready | output | 1 | Complexity results valid |
| used_terms | output | clog2(TERMS+1) | Number of live terms |
| c1_out | output | clog2(TERMS*OUTS+1) | Sum of per-output term counts |
| c2_out | output | clog2(TERMS*TERMS*OUTS+1) | Live terms times total connections |
| c3_out | output | clog2(TERMS*TERMS*OUTS+1) | Sum of squared per-output term counts |
| pat_valid | input | 1 | Training sample present |
| pat_expect | input | OUTS | Class vector the array should give |
| pat_actual | input | OUTS | Class vector the array gave |
| epoch_done | input | 1 | Close the epoch and report |
| rpt_valid | output | 1 | One-cycle pulse after an epoch closes |
| rpt_patterns | output | CNT_W | Samples counted in the closed epoch |
| rpt_errors | output | CNT_W | Wrong samples in the closed epoch |

## Verification
The complexity walk is driven first with the small worked circuit, where C1, C2 and C3 take three different values from the same counts and so expose a swapped formula. It then sees half-built terms (literals without connections, connections without literals), which separate the live-term rule from a plain nonzero test. A fully populated array reaches the widest results, and random mixes with sparse literal fields cover the rest. A restart a few cycles into a walk, with the register changed underneath, shows whether stale partial counts leak into the new result and whether the ready latency is re-timed. Sample streams mix one-bit and multi-bit mismatches, close epochs with and without a same-cycle sample, and run long enough to hold both counts at their ceiling.

// File: rtl/lace_pkg.sv
package lace_pkg;

  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_RUN  = 2'd1,
    SCAN_DONE = 2'd2
  } scan_state_e;

  // Growth of k*k when k becomes k+1.
  function automatic int unsigned square_step(input int unsigned k);
    return 2 * k + 1;
  endfunction

  function automatic int unsigned pair_product(input int unsigned a,
                                               input int unsigned b);
    return a * b;
  endfunction

endpackage

// File: rtl/lace_term_scan.sv
module lace_term_scan
  import lace_pkg::*;
#(
  parameter int IN_BITS = 64,
  parameter int TERMS   = 16,
  parameter int OUTS    = 3,
  localparam int TW     = 2 * IN_BITS + OUTS,
  localparam int ARCH_W = TERMS * TW,
  localparam int IW     = (TERMS > 1) ? $clog2(TERMS) : 1,
  localparam int KW     = $clog2(TERMS + 1),
  localparam int CPW    = $clog2(TERMS * TERMS * OUTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ARCH_W-1:0] arch_bits,
  input  logic              start,
  output logic              ready,
  output logic [OUTS*KW-1:0] k_flat,
  output logic [KW-1:0]     used_q,
  output logic [CPW-1:0]    c3_q,
  output logic              term_live
);

  scan_state_e     state_q;
  logic [IW-1:0]   idx_q;
  logic [KW-1:0]   k_q   [OUTS];
  logic [KW-1:0]   k_nxt [OUTS];
  logic [TW-1:0]   term_tbl [TERMS];
  logic [TW-1:0]   cur;
  logic [OUTS-1:0] cur_conn;
  logic [2*IN_BITS-1:0] cur_lit;
  int unsigned     c3_add;
  logic            last_term;

  for (genvar g = 0; g < TERMS; g++) begin : g_slice
    assign term_tbl[g] = arch_bits[g*TW +: TW];
  end

  for (genvar o = 0; o < OUTS; o++) begin : g_kout
    assign k_flat[o*KW +: KW] = k_q[o];
  end

  assign cur       = term_tbl[idx_q];
  assign cur_conn  = cur[OUTS-1:0];
  assign cur_lit   = cur[TW-1:OUTS];
  assign term_live = (state_q == SCAN_RUN) && (|cur_lit) && (|cur_conn);
  assign last_term = (idx_q == IW'(TERMS - 1));
  assign ready     = (state_q == SCAN_DONE);

  always_comb begin
    c3_add = 0;
    for (int o = 0; o < OUTS; o++) begin
      k_nxt[o] = k_q[o];
      if (term_live && cur_conn[o]) begin
        c3_add   = c3_add + square_step(int'(k_q[o]));
        k_nxt[o] = k_q[o] + KW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      idx_q   <= '0;
      used_q  <= '0;
      c3_q    <= '0;
      for (int o = 0; o < OUTS; o++) k_q[o] <= '0;
    end else if (start) begin
      state_q <= SCAN_RUN;
      idx_q   <= '0;
      used_q  <= '0;
      c3_q    <= '0;
      for (int o = 0; o < OUTS; o++) k_q[o] <= '0;
    end else if (state_q == SCAN_RUN) begin
      for (int o = 0; o < OUTS; o++) k_q[o] <= k_nxt[o];
      c3_q   <= c3_q + CPW'(c3_add);
      used_q <= used_q + KW'(term_live);
      if (last_term) state_q <= SCAN_DONE;
      else           idx_q   <= idx_q + IW'(1);
    end
  end

endmodule

// File: rtl/lace_err_tally.sv
module lace_err_tally #(
  parameter int OUTS  = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pat_valid,
  input  logic [OUTS-1:0]  pat_expect,
  input  logic [OUTS-1:0]  pat_actual,
  input  logic             epoch_done,
  output logic             rpt_valid,
  output logic [CNT_W-1:0] rpt_patterns,
  output logic [CNT_W-1:0] rpt_errors,
  output logic             err_evt,
  output logic [CNT_W-1:0] run_pats,
  output logic [CNT_W-1:0] run_errs
);

  logic [CNT_W-1:0] pats_nxt, errs_nxt;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v,
                                            input logic en);
    return (en && (v != '1)) ? v + CNT_W'(1) : v;
  endfunction

  assign err_evt  = pat_valid && (pat_expect != pat_actual);
  assign pats_nxt = bump(run_pats, pat_valid);
  assign errs_nxt = bump(run_errs, err_evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_pats     <= '0;
      run_errs     <= '0;
      rpt_patterns <= '0;
      rpt_errors   <= '0;
      rpt_valid    <= 1'b0;
    end else if (epoch_done) begin
      rpt_patterns <= pats_nxt;
      rpt_errors   <= errs_nxt;
      rpt_valid    <= 1'b1;
      run_pats     <= '0;
      run_errs     <= '0;
    end else begin
      run_pats  <= pats_nxt;
      run_errs  <= errs_nxt;
      rpt_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/logic_array_cost_eval.sv
module logic_array_cost_eval
  import lace_pkg::*;
#(
  parameter int IN_BITS = 64,
  parameter int TERMS   = 16,
  parameter int OUTS    = 3,
  parameter int CNT_W   = 8,
  localparam int TW     = 2 * IN_BITS + OUTS,
  localparam int ARCH_W = TERMS * TW,
  localparam int KW     = $clog2(TERMS + 1),
  localparam int C1W    = $clog2(TERMS * OUTS + 1),
  localparam int CPW    = $clog2(TERMS * TERMS * OUTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ARCH_W-1:0] arch_bits,
  input  logic              scan_start,
  output logic              scan_ready,
  output logic [KW-1:0]     used_terms,
  output logic [C1W-1:0]    c1_out,
  output logic [CPW-1:0]    c2_out,
  output logic [CPW-1:0]    c3_out,
  input  logic              pat_valid,
  input  logic [OUTS-1:0]   pat_expect,
  input  logic [OUTS-1:0]   pat_actual,
  input  logic              epoch_done,
  output logic              rpt_valid,
  output logic [CNT_W-1:0]  rpt_patterns,
  output logic [CNT_W-1:0]  rpt_errors
);

  logic [OUTS*KW-1:0] k_flat;
  logic               term_live;
  logic               err_evt;
  logic [CNT_W-1:0]   run_pats, run_errs;

  lace_term_scan #(.IN_BITS(IN_BITS), .TERMS(TERMS), .OUTS(OUTS)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .arch_bits (arch_bits),
    .start     (scan_start),
    .ready     (scan_ready),
    .k_flat    (k_flat),
    .used_q    (used_terms),
    .c3_q      (c3_out),
    .term_live (term_live)
  );

  always_comb begin
    c1_out = '0;
    for (int o = 0; o < OUTS; o++) c1_out = c1_out + C1W'(k_flat[o*KW +: KW]);
  end

  assign c2_out = CPW'(pair_product(int'(used_terms), int'(c1_out)));

  lace_err_tally #(.OUTS(OUTS), .CNT_W(CNT_W)) u_tally (
    .clk          (clk),
    .rst_n        (rst_n),
    .pat_valid    (pat_valid),
    .pat_expect   (pat_expect),
    .pat_actual   (pat_actual),
    .epoch_done   (epoch_done),
    .rpt_valid    (rpt_valid),
    .rpt_patterns (rpt_patterns),
    .rpt_errors   (rpt_errors),
    .err_evt      (err_evt),
    .run_pats     (run_pats),
    .run_errs     (run_errs)
  );

endmodule

// File: rtl/logic_array_cost_eval_chk.sv
module logic_array_cost_eval_chk #(
  parameter int OUTS  = 3,
  parameter int KW    = 5,
  parameter int C1W   = 6,
  parameter int CPW   = 10,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_start,
  input logic             scan_ready,
  input logic [KW-1:0]    used_terms,
  input logic [C1W-1:0]   c1_out,
  input logic [CPW-1:0]   c2_out,
  input logic [CPW-1:0]   c3_out,
  input logic             term_live,
  input logic             epoch_done,
  input logic             rpt_valid,
  input logic             err_evt,
  input logic [CNT_W-1:0] run_pats,
  input logic [CNT_W-1:0] run_errs
);

  // R6
  restart_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |=> !scan_ready);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_ready && !scan_start) |=>
      (scan_ready && $stable(c1_out) && $stable(c2_out) && $stable(c3_out) && $stable(used_terms)));

  // R1
  live_only_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_live |-> !scan_ready);

  // R2
  c1_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(c1_out) >= int'(used_terms)) && (int'(c1_out) <= int'(used_terms) * OUTS));

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_done |=> run_errs >= $past(run_errs));

  // R7
  err_within_pats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_errs <= run_pats);

  // R7
  err_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !epoch_done && run_pats == '0) |=> run_pats != '0);

  // R9
  report_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_done |=> rpt_valid);

  // R9
  report_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_done |=> !rpt_valid);

endmodule

bind logic_array_cost_eval logic_array_cost_eval_chk #(
  .OUTS(OUTS), .KW(KW), .C1W(C1W), .CPW(CPW), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scan_start (scan_start),
  .scan_ready (scan_ready),
  .used_terms (used_terms),
  .c1_out     (c1_out),
  .c2_out     (c2_out),
  .c3_out     (c3_out),
  .term_live  (term_live),
  .epoch_done (epoch_done),
  .rpt_valid  (rpt_valid),
  .err_evt    (err_evt),
  .run_pats   (run_pats),
  .run_errs   (run_errs)
);

// File: tb/logic_array_cost_eval_test.sv
module logic_array_cost_eval_test;

  localparam int IN_BITS = 64;
  localparam int TERMS   = 16;
  localparam int OUTS    = 3;
  localparam int CNT_W   = 8;
  localparam int TW      = 2 * IN_BITS + OUTS;
  localparam int ARCH_W  = TERMS * TW;
  localparam int KW      = $clog2(TERMS + 1);
  localparam int C1W     = $clog2(TERMS * OUTS + 1);
  localparam int CPW     = $clog2(TERMS * TERMS * OUTS + 1);
  localparam int SAT     = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ARCH_W-1:0] arch_bits = '0;
  logic              scan_start = 1'b0;
  logic              scan_ready;
  logic [KW-1:0]     used_terms;
  logic [C1W-1:0]    c1_out;
  logic [CPW-1:0]    c2_out, c3_out;
  logic              pat_valid = 1'b0;
  logic [OUTS-1:0]   pat_expect = '0, pat_actual = '0;
  logic              epoch_done = 1'b0;
  logic              rpt_valid;
  logic [CNT_W-1:0]  rpt_patterns, rpt_errors;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  logic_array_cost_eval #(.IN_BITS(IN_BITS), .TERMS(TERMS), .OUTS(OUTS), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .arch_bits(arch_bits), .scan_start(scan_start),
    .scan_ready(scan_ready), .used_terms(used_terms), .c1_out(c1_out),
    .c2_out(c2_out), .c3_out(c3_out), .pat_valid(pat_valid),
    .pat_expect(pat_expect), .pat_actual(pat_actual), .epoch_done(epoch_done),
    .rpt_valid(rpt_valid), .rpt_patterns(rpt_patterns), .rpt_errors(rpt_errors)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_term(input int t, input logic [2*IN_BITS-1:0] lit,
                          input logic [OUTS-1:0] conn);
    arch_bits[t*TW +: TW] = {lit, conn};
  endtask

  // Independent model: square by multiplication, product from totals.
  task automatic model(output int u, output int e1, output int e2, output int e3);
    int k[OUTS];
    u = 0; e1 = 0; e3 = 0;
    for (int o = 0; o < OUTS; o++) k[o] = 0;
    for (int t = 0; t < TERMS; t++) begin
      logic [TW-1:0] w;
      w = arch_bits[t*TW +: TW];
      if (w[TW-1:OUTS] != '0 && w[OUTS-1:0] != '0) begin
        u++;
        for (int o = 0; o < OUTS; o++) if (w[o]) k[o]++;
      end
    end
    for (int o = 0; o < OUTS; o++) begin
      e1 += k[o];
      e3 += k[o] * k[o];
    end
    e2 = u * e1;
  endtask

  // Pulse start at a negedge; check ready latency; compare results.
  task automatic scan_and_check(input string tag);
    int u, e1, e2, e3;
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    chk({tag, " R6 ready low after start"}, int'(scan_ready), 0);
    for (int i = 1; i <= TERMS; i++) begin
      @(negedge clk);
      if (i == TERMS - 1) chk({tag, " R5 not ready early"}, int'(scan_ready), 0);
    end
    chk({tag, " R5 ready on time"}, int'(scan_ready), 1);
    model(u, e1, e2, e3);
    chk({tag, " R1 used terms"}, int'(used_terms), u);
    chk({tag, " R2 C1"}, int'(c1_out), e1);
    chk({tag, " R3 C2"}, int'(c2_out), e2);
    chk({tag, " R4 C3"}, int'(c3_out), e3);
  endtask

  function automatic logic [2*IN_BITS-1:0] rand_lit();
    logic [2*IN_BITS-1:0] v;
    for (int i = 0; i < 2*IN_BITS; i += 32) v[i +: 32] = $urandom;
    if ($urandom % 3 == 0) v = '0;
    else if ($urandom % 2 == 0) v = v & (v >> 7) & (v << 13);
    return v;
  endfunction

  int ep_pats, ep_errs;

  task automatic send(input logic [OUTS-1:0] e, input logic [OUTS-1:0] a);
    pat_valid = 1'b1; pat_expect = e; pat_actual = a;
    @(negedge clk);
    pat_valid = 1'b0;
    if (ep_pats < SAT) ep_pats++;
    if (e != a && ep_errs < SAT) ep_errs++;
  endtask

  task automatic close_epoch(input string tag, input bit with_pat);
    logic [OUTS-1:0] e, a;
    if (with_pat) begin
      e = OUTS'($urandom); a = e ^ OUTS'(3);
      pat_valid = 1'b1; pat_expect = e; pat_actual = a;
      if (ep_pats < SAT) ep_pats++;
      if (ep_errs < SAT) ep_errs++;
    end
    epoch_done = 1'b1;
    @(negedge clk);
    epoch_done = 1'b0; pat_valid = 1'b0;
    chk({tag, " R9 report pulse"}, int'(rpt_valid), 1);
    chk({tag, " R7 sample count"}, int'(rpt_patterns), ep_pats);
    chk({tag, " R7 error count"}, int'(rpt_errors), ep_errs);
    @(negedge clk);
    chk({tag, " R9 pulse one cycle"}, int'(rpt_valid), 0);
    chk({tag, " R9 report held"}, int'(rpt_patterns), ep_pats);
    ep_pats = 0; ep_errs = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    ep_pats = 0; ep_errs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ready", int'(scan_ready), 0);
    chk("R10 rpt_valid", int'(rpt_valid), 0);
    chk("R10 C1", int'(c1_out), 0);
    chk("R10 C3", int'(c3_out), 0);
    chk("R10 rpt_patterns", int'(rpt_patterns), 0);
    chk("R10 rpt_errors", int'(rpt_errors), 0);

    // R4 worked circuit: one term on output 0, two on output 1
    arch_bits = '0;
    put_term(0, 128'h1, 3'b001);
    put_term(5, 128'h80, 3'b010);
    put_term(9, {1'b1, 127'h0}, 3'b010);
    scan_and_check("worked");
    chk("R4 worked C1=3", int'(c1_out), 3);
    chk("R4 worked C2=9", int'(c2_out), 9);
    chk("R4 worked C3=5", int'(c3_out), 5);

    // R1 half-built terms are not live
    put_term(2, 128'h10, 3'b000);
    put_term(3, '0, 3'b111);
    scan_and_check("halfterm");
    chk("R1 half terms ignored", int'(used_terms), 3);

    // Fully populated array
    for (int t = 0; t < TERMS; t++) put_term(t, '1, '1);
    scan_and_check("full");

    // Random configurations
    for (int n = 0; n < 20; n++) begin
      for (int t = 0; t < TERMS; t++) put_term(t, rand_lit(), OUTS'($urandom));
      scan_and_check("random");
    end

    // R6 restart mid-walk with new contents
    for (int t = 0; t < TERMS; t++) put_term(t, '1, 3'b111);
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    repeat (5) @(negedge clk);
    arch_bits = '0;
    put_term(1, 128'h4, 3'b100);
    put_term(TERMS - 1, 128'h2, 3'b101);
    scan_and_check("restart");
    chk("R6 restart C3", int'(c3_out), 5);

    // R5 results stay while idle
    repeat (7) @(negedge clk);
    chk("R5 hold ready", int'(scan_ready), 1);
    chk("R5 hold C2", int'(c2_out), 6);

    // R7 directed one-bit and multi-bit mismatches
    send(3'b101, 3'b101);
    send(3'b101, 3'b100);
    send(3'b010, 3'b101);
    send(3'b000, 3'b000);
    close_epoch("directed", 1'b0);

    // R9 empty epoch after a close reports zero
    close_epoch("empty", 1'b0);

    // Random epochs, some closed with a same-cycle sample
    for (int n = 0; n < 6; n++) begin
      int cnt;
      cnt = 5 + int'($urandom % 40);
      for (int i = 0; i < cnt; i++) begin
        logic [OUTS-1:0] e, a;
        e = OUTS'($urandom);
        a = ($urandom % 3 == 0) ? OUTS'($urandom) : e;
        send(e, a);
      end
      close_epoch("random", n[0]);
    end

    // R8 saturation of both counts
    for (int i = 0; i < SAT + 40; i++) send(3'b001, 3'b110);
    close_epoch("R8 saturate", 1'b1);
    chk("R8 saturated errors", int'(rpt_errors), SAT);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule